// File: doc/BRIEF.md
# Nested Page-Table Entry Fault Classifier

This block judges a single second-level translation entry, one that points to a next-level page table, against one memory access. It looks at the entry's permission field, its reserved bits and the requested access kind. It then reports whether the access is allowed, whether it breaks the entry's permissions, or whether the entry itself is malformed. Which reserved bits must be zero depends on the physical-address width, which is a parameter.

A table walker presents the entry with a one-cycle `inValid` strobe. One clock later the block returns a registered result code, a request to set the entry's accessed flag, and the 4 KiB aligned base address of the next-level table. The result code and base address then stay unchanged until the next strobe.

Top module: `nptc_classifier`

## Requirements
- R1: The outputs are registered. `outValid` is high in exactly the cycle after each cycle in which `inValid` is high, and low otherwise. `resultCode` takes 2'b00 for OK, 2'b01 for violation and 2'b10 for misconfiguration, and never takes 2'b11. `resultCode` and `tableBase` keep their values until the next strobe.
- R2: A permission field `entry[2:0]` of 3'b010 or 3'b110 gives misconfiguration for every access kind.
- R3: A permission field of 3'b100 gives misconfiguration when `execOnlyCap` is 0. When `execOnlyCap` is 1 it is a legal entry: a fetch is OK and a read or a write is a violation.
- R4: An entry with `entry[2:0]` = 3'b000 is not present. It gives violation for every access kind, whatever its other bits hold, and never gives misconfiguration.
- R5: A present entry with any of bits 7:3 set gives misconfiguration.
- R6: A present entry with any bit from 51 down to PA_WIDTH set gives misconfiguration. Bits 11:9, 63:52 and PA_WIDTH-1:12 have no effect on the result.
- R7: The access kind is encoded as 2'b00 read (needs bit 0), 2'b01 write (needs bit 1), 2'b10 fetch (needs bit 2) and 2'b11, which is treated as a read. On a legal present entry, the result is violation when the needed bit is 0 and OK when it is 1.
- R8: Misconfiguration takes precedence: a malformed entry that would also deny the access gives 2'b10.
- R9: `accessedReq` pulses together with `outValid` only when three conditions hold: the result is OK, `adFlagEnable` is 1, and `entry[8]` is 0. When `adFlagEnable` is 0, bit 8 has no effect on any output.
- R10: `tableBase` equals `entry[PA_WIDTH-1:12]` shifted left by 12 and zero-extended to 64 bits. Its low 12 bits are always zero.
- R11: After reset, `outValid` and `accessedReq` are 0, `resultCode` is 2'b00 and `tableBase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: entry and access are valid this cycle |
| entry | input | 64 | Translation entry under test |
| accessKind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| execOnlyCap | input | 1 | Execute-only permission encoding is supported |
| adFlagEnable | input | 1 | Accessed-flag tracking enabled by the table pointer |
| outValid | output | 1 | Result valid pulse |
| resultCode | output | 2 | 00 OK, 01 violation, 10 misconfiguration |
| accessedReq | output | 1 | Request to set the entry's accessed flag |
| tableBase | output | 64 | Next-level table base address |

## Verification
Several properties are checked by assertions on every cycle: the one-cycle strobe-to-valid timing, the absence of the code 2'b11, the zero low bits of the base address, and the fact that `accessedReq` only accompanies an OK result with tracking enabled. Assertions also cover the fixed outcomes of the illegal permission encodings, the non-present encoding and set bits 7:3. The bench scenarios are needed for the rest: the reserved-field boundary at PA_WIDTH, the fields that must be ignored, the execute-only capability switch, and the mapping of each access kind to its permission bit. The same holds for result hold between strobes and for the exact base address value.

// File: rtl/nptc_pkg.sv
package nptc_pkg;

  typedef enum logic [1:0] {
    RES_OK     = 2'b00,
    RES_VIOL   = 2'b01,
    RES_MISCFG = 2'b10
  } resultE;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } accessE;

  // Decoded facts about the entry, produced by the datapath
  typedef struct packed {
    logic present;
    logic permIllegal;
    logic rsvSet;
    logic denied;
    logic flagClear;
  } decodeT;

  // Strobes from control to datapath
  typedef struct packed {
    logic   load;
    resultE code;
    logic   raiseReq;
  } strobeT;

endpackage

// File: rtl/nptc_datapath.sv
module nptc_datapath
  import nptc_pkg::*;
#(
  parameter int PA_WIDTH = 48,
  parameter int ENTRY_W  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRY_W-1:0] entry,
  input  logic [1:0]         accessKind,
  input  logic               execOnlyCap,
  input  strobeT             strb,
  output decodeT             dec,
  output logic [1:0]         resultCode,
  output logic               accessedReq,
  output logic [ENTRY_W-1:0] tableBase
);

  localparam int RSV_TOP   = 52;
  localparam int PAGE_BITS = 12;
  localparam int PERM_W    = 3;
  localparam logic [ENTRY_W-1:0] RSV_MASK =
      ((ENTRY_W'(1) << RSV_TOP) - ENTRY_W'(1)) &
      ~((ENTRY_W'(1) << PA_WIDTH) - ENTRY_W'(1));
  localparam logic [ENTRY_W-1:0] BASE_MASK =
      ((ENTRY_W'(1) << PA_WIDTH) - ENTRY_W'(1)) &
      ~((ENTRY_W'(1) << PAGE_BITS) - ENTRY_W'(1));

  logic [PERM_W-1:0] perm;
  logic              needBit;

  assign perm = entry[PERM_W-1:0];

  always_comb begin
    dec.present     = (perm != 3'b000);
    dec.permIllegal = (perm == 3'b010) || (perm == 3'b110) ||
                      ((perm == 3'b100) && !execOnlyCap);
    dec.rsvSet      = (entry[7:3] != 5'd0) || ((entry & RSV_MASK) != '0);
    dec.flagClear   = !entry[8];
  end

  always_comb begin
    unique case (accessE'(accessKind))
      ACC_WRITE: needBit = entry[1];
      ACC_FETCH: needBit = entry[2];
      default:   needBit = entry[0];
    endcase
    dec.denied = !needBit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resultCode  <= RES_OK;
      accessedReq <= 1'b0;
      tableBase   <= '0;
    end else begin
      accessedReq <= strb.load && strb.raiseReq;
      if (strb.load) begin
        resultCode <= strb.code;
        tableBase  <= entry & BASE_MASK;
      end
    end
  end

endmodule

// File: rtl/nptc_ctrl.sv
module nptc_ctrl
  import nptc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   inValid,
  input  logic   adFlagEnable,
  input  decodeT dec,
  output strobeT strb,
  output logic   outValid
);

  resultE code;

  // Precedence: malformed entry, then absent entry, then permission check
  always_comb begin
    if (dec.present && (dec.permIllegal || dec.rsvSet))
      code = RES_MISCFG;
    else if (!dec.present || dec.denied)
      code = RES_VIOL;
    else
      code = RES_OK;
  end

  always_comb begin
    strb.load     = inValid;
    strb.code     = code;
    strb.raiseReq = (code == RES_OK) && adFlagEnable && dec.flagClear;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

endmodule

// File: rtl/nptc_classifier.sv
module nptc_classifier
  import nptc_pkg::*;
#(
  parameter int PA_WIDTH = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [63:0] entry,
  input  logic [1:0]  accessKind,
  input  logic        execOnlyCap,
  input  logic        adFlagEnable,
  output logic        outValid,
  output logic [1:0]  resultCode,
  output logic        accessedReq,
  output logic [63:0] tableBase
);

  decodeT dec;
  strobeT strb;

  nptc_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .inValid      (inValid),
    .adFlagEnable (adFlagEnable),
    .dec          (dec),
    .strb         (strb),
    .outValid     (outValid)
  );

  nptc_datapath #(.PA_WIDTH(PA_WIDTH), .ENTRY_W(64)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry       (entry),
    .accessKind  (accessKind),
    .execOnlyCap (execOnlyCap),
    .strb        (strb),
    .dec         (dec),
    .resultCode  (resultCode),
    .accessedReq (accessedReq),
    .tableBase   (tableBase)
  );

endmodule

// File: rtl/nptc_checker.sv
module nptc_checker #(
  parameter int PA_WIDTH = 48
) (
  input logic        clk,
  input logic        rst_n,
  input logic        inValid,
  input logic [63:0] entry,
  input logic [1:0]  accessKind,
  input logic        execOnlyCap,
  input logic        adFlagEnable,
  input logic        outValid,
  input logic [1:0]  resultCode,
  input logic        accessedReq,
  input logic [63:0] tableBase
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);                                             // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);                                           // R1
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    resultCode != 2'b11);                                              // R1
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(resultCode) && $stable(tableBase));           // R1
  AST_WRITE_ONLY_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && (entry[1:0] == 2'b10) |=> resultCode == 2'b10);         // R2
  AST_ABSENT_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && (entry[2:0] == 3'b000) |=> resultCode == 2'b01);        // R4
  AST_LOW_RSV_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && (entry[2:0] != 3'b000) && (entry[7:3] != 5'd0)
      |=> resultCode == 2'b10);                                        // R5
  AST_REQ_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
    accessedReq |-> outValid && (resultCode == 2'b00));                // R9
  AST_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !adFlagEnable |=> !accessedReq);                        // R9
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    tableBase[11:0] == 12'd0);                                         // R10

endmodule

bind nptc_classifier nptc_checker #(.PA_WIDTH(PA_WIDTH)) u_nptc_checker (.*);

// File: tb/test_nptc_classifier.sv
module test_nptc_classifier;

  localparam int CLK_PERIOD = 10;
  localparam int PAW        = 48;
  localparam logic [63:0] BASE_MASK =
      ((64'd1 << PAW) - 64'd1) & ~64'hFFF;
  localparam int NV = 27;

  // {entry, kind, cap, adEn, expCode, expReq, reqTag}
  localparam logic [74:0] VECS [NV] = '{
    {64'h0000_0000_0000_0007, 2'd0, 1'b0, 1'b0, 2'b00, 1'b0, 4'd7},  // R7 read RWX
    {64'h0000_0000_0000_0003, 2'd1, 1'b0, 1'b0, 2'b00, 1'b0, 4'd7},  // R7 write RW
    {64'h0000_0000_0000_0001, 2'd1, 1'b0, 1'b0, 2'b01, 1'b0, 4'd7},  // R7 write denied
    {64'h0000_0000_0000_0003, 2'd2, 1'b0, 1'b0, 2'b01, 1'b0, 4'd7},  // R7 fetch denied
    {64'h0000_0000_0000_0005, 2'd2, 1'b0, 1'b0, 2'b00, 1'b0, 4'd7},  // R7 fetch ok
    {64'h0000_0000_0000_0001, 2'd3, 1'b0, 1'b0, 2'b00, 1'b0, 4'd7},  // R7 kind 11 as read
    {64'h0000_0000_0000_0004, 2'd3, 1'b1, 1'b0, 2'b01, 1'b0, 4'd7},  // R7 kind 11 denied
    {64'h0000_0000_0000_0002, 2'd0, 1'b0, 1'b0, 2'b10, 1'b0, 4'd2},  // R2 010
    {64'h0000_0000_0000_0006, 2'd2, 1'b1, 1'b0, 2'b10, 1'b0, 4'd2},  // R2 110
    {64'h0000_0000_0000_0004, 2'd2, 1'b0, 1'b0, 2'b10, 1'b0, 4'd3},  // R3 no cap
    {64'h0000_0000_0000_0004, 2'd2, 1'b1, 1'b0, 2'b00, 1'b0, 4'd3},  // R3 cap fetch
    {64'h0000_0000_0000_0004, 2'd0, 1'b1, 1'b0, 2'b01, 1'b0, 4'd3},  // R3 cap read
    {64'h0000_0000_0000_0000, 2'd0, 1'b0, 1'b0, 2'b01, 1'b0, 4'd4},  // R4 absent
    {64'h0004_0000_0000_0080, 2'd2, 1'b0, 1'b0, 2'b01, 1'b0, 4'd4},  // R4 absent with junk
    {64'h0000_0000_0000_0089, 2'd0, 1'b0, 1'b0, 2'b10, 1'b0, 4'd5},  // R5 bit7
    {64'h0000_0000_0000_0041, 2'd0, 1'b0, 1'b0, 2'b10, 1'b0, 4'd5},  // R5 bit6
    {64'h0000_0000_0000_0009, 2'd0, 1'b0, 1'b0, 2'b10, 1'b0, 4'd5},  // R5 bit3
    {64'h0008_0000_0000_0001, 2'd0, 1'b0, 1'b0, 2'b10, 1'b0, 4'd6},  // R6 bit51
    {64'h0001_0000_0000_0001, 2'd0, 1'b0, 1'b0, 2'b10, 1'b0, 4'd6},  // R6 bit48
    {64'hFFF0_8000_0000_0E01, 2'd0, 1'b0, 1'b0, 2'b00, 1'b0, 4'd6},  // R6 ignored fields
    {64'h0000_0000_0000_0081, 2'd1, 1'b0, 1'b0, 2'b10, 1'b0, 4'd8},  // R8 bit7 + deny
    {64'h0000_0000_0000_0002, 2'd2, 1'b0, 1'b0, 2'b10, 1'b0, 4'd8},  // R8 010 + deny
    {64'h0000_0000_1234_5007, 2'd0, 1'b0, 1'b1, 2'b00, 1'b1, 4'd9},  // R9 request
    {64'h0000_0000_1234_5107, 2'd0, 1'b0, 1'b1, 2'b00, 1'b0, 4'd9},  // R9 already set
    {64'h0000_0000_1234_5007, 2'd0, 1'b0, 1'b0, 2'b00, 1'b0, 4'd9},  // R9 disabled
    {64'h0000_0000_0000_0001, 2'd1, 1'b0, 1'b1, 2'b01, 1'b0, 4'd9},  // R9 no req on viol
    {64'h0000_0000_0000_0101, 2'd0, 1'b0, 1'b0, 2'b00, 1'b0, 4'd9}   // R9 bit8 ignored
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inValid;
  logic [63:0] entry;
  logic [1:0]  accessKind;
  logic        execOnlyCap;
  logic        adFlagEnable;
  logic        outValid;
  logic [1:0]  resultCode;
  logic        accessedReq;
  logic [63:0] tableBase;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  nptc_classifier #(.PA_WIDTH(PAW)) i_nptc_classifier (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .entry(entry),
    .accessKind(accessKind), .execOnlyCap(execOnlyCap),
    .adFlagEnable(adFlagEnable), .outValid(outValid),
    .resultCode(resultCode), .accessedReq(accessedReq),
    .tableBase(tableBase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] e, input logic [1:0] k,
                       input logic cap, input logic ad);
    @(negedge clk);
    entry = e; accessKind = k; execOnlyCap = cap; adFlagEnable = ad;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; inValid = 1'b0; entry = '0; accessKind = '0;
    execOnlyCap = 1'b0; adFlagEnable = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 outValid", 64'(outValid), 64'd0);
    check("R11 resultCode", 64'(resultCode), 64'd0);
    check("R11 accessedReq", 64'(accessedReq), 64'd0);
    check("R11 tableBase", tableBase, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [63:0] e;
      string tag;
      e = VECS[i][74:11];
      tag = $sformatf("R%0d vec%0d", VECS[i][3:0], i);
      apply(e, VECS[i][10:9], VECS[i][8], VECS[i][7]);
      check({tag, " valid"}, 64'(outValid), 64'd1);
      check({tag, " code"}, 64'(resultCode), 64'(VECS[i][6:5]));
      check({tag, " req"}, 64'(accessedReq), 64'(VECS[i][4]));
      check({"R10 base ", tag}, tableBase, e & BASE_MASK);
    end

    // R1 hold and idle: inputs change without strobe
    apply(64'h0000_0000_00AB_C002, 2'd0, 1'b0, 1'b0);
    entry = 64'h0000_0000_0000_0007;
    repeat (3) @(negedge clk);
    check("R1 idle valid", 64'(outValid), 64'd0);
    check("R1 hold code", 64'(resultCode), 64'd2);
    check("R1 hold base", tableBase, 64'h0000_0000_00AB_C000);

    // R1 back-to-back strobes
    @(negedge clk);
    entry = 64'h0000_0000_0000_0001; accessKind = 2'd0; inValid = 1'b1;
    @(negedge clk);
    check("R1 b2b first valid", 64'(outValid), 64'd1);
    check("R1 b2b first code", 64'(resultCode), 64'd0);
    entry = 64'h0000_0000_0000_0000;
    @(negedge clk);
    inValid = 1'b0;
    check("R1 b2b second valid", 64'(outValid), 64'd1);
    check("R4 b2b second code", 64'(resultCode), 64'd1);
    @(negedge clk);
    check("R1 valid drops", 64'(outValid), 64'd0);

    // R10 top of base range
    apply(64'h0000_FFFF_FFFF_F007, 2'd0, 1'b0, 1'b0);
    check("R10 full base", tableBase, 64'h0000_FFFF_FFFF_F000);
    check("R6 full base ok", 64'(resultCode), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule